// File: doc/BRIEF.md
# Mailbox Command Execution Engine

This block sits on the host side of a coprocessor link and turns a single command request into the word-access sequence that makes the coprocessor run a numbered software interrupt. For an execute command it stores the interrupt number at a fixed word address. It then stores a block of parameter words at consecutive word addresses. Last, it writes the execute trigger into the mailbox register. A reset command skips the memory writes and places only the reset trigger in the mailbox. A port-reset command is an execute command whose interrupt number and first two parameters the engine builds itself.

After the trigger the engine watches the mailbox-out flag. When the flag appears, it reads the mailbox register and classifies the reply word. If the flag does not appear within a bounded window, it reports a timeout instead. Only one command is in flight at a time. The engine refuses new requests from acceptance until the response has been taken.

Top module: `mbx_cmd_engine`

## Requirements
- R1: Command kinds 0 and 3 (execute) start with a memory write of `cmd_intnum` to word address 0x01C2.
- R2: For execute, parameter word i (bits 16i+15..16i of `cmd_params`) is then written to address 0x01C4 + 2*i, for i from 0 up to NPARAM-1 in ascending order.
- R3: For execute, the last write is 0xCE01 to the mailbox register (`m_mbx`=1, `m_we`=1), after all parameter writes.
- R4: Kind 1 (reset) makes no memory write: its only write is 0xFA50 to the mailbox register.
- R5: Kind 2 (port reset) follows the execute sequence with interrupt number 0x0074, parameter 0 = 50, parameter 1 = `cmd_port` | (`cmd_unit` << 1), and every other parameter 0. `cmd_intnum` and `cmd_params` are ignored for this kind.
- R6: After the trigger the engine waits for `mbx_flag`, then makes one mailbox read (`m_mbx`=1, `m_we`=0). The word it reads is returned on `rsp_word`.
- R7: `rsp_code` is 0 for a reply of 0x0FED, 1 for 0xDEAD and 2 for any other reply.
- R8: If `mbx_flag` stays low for TIMEOUT_CYCLES cycles while waiting, the response has code 3 and word 0, and no mailbox read is made.
- R9: `busy` is high and `cmd_ready` low from acceptance until the response is accepted. A request presented during that time starts no access.
- R10: `rsp_valid`, `rsp_code` and `rsp_word` hold steady until `rsp_ready` is seen.
- R11: While `m_req` is high and `m_gnt` low, the engine keeps request, address, data, direction and target unchanged.
- R12: After reset, `busy`, `m_req` and `rsp_valid` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_kind | input | 2 | 0/3 execute, 1 reset, 2 port reset |
| cmd_intnum | input | 16 | Software interrupt number |
| cmd_params | input | NPARAM*16 | Parameter words, word i at bits 16i+15..16i |
| cmd_port | input | 1 | Port select for port reset |
| cmd_unit | input | 1 | Engine index for port reset |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_code | output | 2 | 0 ack, 1 nak, 2 other, 3 timeout |
| rsp_word | output | 16 | Raw reply word (0 on timeout) |
| busy | output | 1 | A command is in flight |
| m_req | output | 1 | Master access request |
| m_we | output | 1 | 1 write, 0 read |
| m_mbx | output | 1 | 1 mailbox register, 0 memory word at m_addr |
| m_addr | output | 16 | Memory word address |
| m_wdata | output | 16 | Write data |
| m_gnt | input | 1 | Access completes this cycle |
| m_rdata | input | 16 | Read data, valid with m_gnt |
| mbx_flag | input | 1 | Mailbox-out flag from the status |

## Verification
The hardest case to reach is the race between the reply flag and the timeout window. With the default window this takes millions of cycles, so the bench builds the engine with a short window. Its device model raises the flag a set number of cycles after it sees the trigger write. One run places the flag a few cycles inside the limit, and other runs never raise it. The device model also stretches grants by varying latencies. This exercises the hold rule and the order of the parameter writes under backpressure.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic [1:0] {
      RSP_ACK     = 2'd0,
      RSP_NAK     = 2'd1,
      RSP_OTHER   = 2'd2,
      RSP_TIMEOUT = 2'd3
   } rsp_code_e;

   typedef enum logic [1:0] {
      KIND_EXEC     = 2'd0,
      KIND_RESET    = 2'd1,
      KIND_PORTRST  = 2'd2,
      KIND_EXEC_ALT = 2'd3
   } cmd_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WMEM,
      ST_WMBX,
      ST_WAIT,
      ST_RMBX,
      ST_RESP
   } eng_state_e;

   localparam logic [15:0] TRIG_EXEC  = 16'hCE01;
   localparam logic [15:0] TRIG_RESET = 16'hFA50;
   localparam logic [15:0] REPLY_ACK  = 16'h0FED;
   localparam logic [15:0] REPLY_NAK  = 16'hDEAD;
endpackage

// File: rtl/mbx_word_src.sv
module mbx_word_src
   import mbx_pkg::*;
#(
   parameter int          NPARAM         = 14,
   parameter int          IW             = 4,
   parameter logic [15:0] INTNUM_ADDR    = 16'h01C2,
   parameter logic [15:0] PARAM_BASE     = 16'h01C4,
   parameter int          ADDR_STRIDE    = 2,
   parameter logic [15:0] PORTRST_INTNUM = 16'h0074,
   parameter logic [15:0] PORTRST_MS     = 16'd50
) (
   input  logic                  portrst,
   input  logic [15:0]           intnum,
   input  logic [NPARAM*16-1:0]  params,
   input  logic                  port,
   input  logic                  unit,
   input  logic [IW-1:0]         idx,
   output logic [15:0]           addr,
   output logic [15:0]           word
);
   logic [15:0]   eff [NPARAM];
   logic [IW-1:0] pidx;

   assign pidx = idx - 1'b1;

   for (genvar g = 0; g < NPARAM; g++) begin : g_eff
      if (g == 0) begin : g_dur
         assign eff[g] = portrst ? PORTRST_MS : params[g*16 +: 16];
      end else if (g == 1) begin : g_sel
         assign eff[g] = portrst ? {14'd0, unit, port} : params[g*16 +: 16];
      end else begin : g_rest
         assign eff[g] = portrst ? 16'd0 : params[g*16 +: 16];
      end
   end

   always_comb begin
      addr = INTNUM_ADDR;
      word = portrst ? PORTRST_INTNUM : intnum;
      if (idx != '0) begin
         addr = PARAM_BASE + 16'(ADDR_STRIDE) * 16'(pidx);
         word = 16'd0;
         for (int i = 0; i < NPARAM; i++) begin
            if (pidx == IW'(i)) word = eff[i];
         end
      end
   end
endmodule

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
   parameter int LIMIT = 240_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   if (LIMIT < 2) begin : g_bad_limit
      $error("mbx_wait_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign expired = run && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt <= '0;
      else if (run && !expired) cnt <= cnt + 1'b1;
   end

   AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) < LIMIT);  // R8
endmodule

// File: rtl/mbx_reply_class.sv
module mbx_reply_class
   import mbx_pkg::*;
(
   input  logic [15:0] reply,
   output rsp_code_e   code
);
   always_comb begin
      if (reply == REPLY_ACK)      code = RSP_ACK;
      else if (reply == REPLY_NAK) code = RSP_NAK;
      else                         code = RSP_OTHER;
   end
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
   import mbx_pkg::*;
#(
   parameter int          NPARAM         = 14,
   parameter int          TIMEOUT_CYCLES = 240_000_000,
   parameter logic [15:0] INTNUM_ADDR    = 16'h01C2,
   parameter logic [15:0] PARAM_BASE     = 16'h01C4,
   parameter int          ADDR_STRIDE    = 2,
   parameter logic [15:0] PORTRST_INTNUM = 16'h0074,
   parameter logic [15:0] PORTRST_MS     = 16'd50
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   output logic                  cmd_ready,
   input  logic [1:0]            cmd_kind,
   input  logic [15:0]           cmd_intnum,
   input  logic [NPARAM*16-1:0]  cmd_params,
   input  logic                  cmd_port,
   input  logic                  cmd_unit,
   output logic                  rsp_valid,
   input  logic                  rsp_ready,
   output logic [1:0]            rsp_code,
   output logic [15:0]           rsp_word,
   output logic                  busy,
   output logic                  m_req,
   output logic                  m_we,
   output logic                  m_mbx,
   output logic [15:0]           m_addr,
   output logic [15:0]           m_wdata,
   input  logic                  m_gnt,
   input  logic [15:0]           m_rdata,
   input  logic                  mbx_flag
);
   localparam int IW = $clog2(NPARAM + 1);

   if (NPARAM < 2) begin : g_bad_nparam
      $error("mbx_cmd_engine: NPARAM must be at least 2");
   end
   if (ADDR_STRIDE < 1) begin : g_bad_stride
      $error("mbx_cmd_engine: ADDR_STRIDE must be positive");
   end

   eng_state_e            st;
   cmd_kind_e             kind_q;
   logic [15:0]           intnum_q;
   logic [NPARAM*16-1:0]  par_q;
   logic                  port_q;
   logic                  unit_q;
   logic [IW-1:0]         idx;
   rsp_code_e             code_q;
   logic [15:0]           word_q;

   logic [15:0]           src_addr;
   logic [15:0]           src_word;
   rsp_code_e             cls_code;
   logic                  t_expired;
   logic                  is_reset;

   assign is_reset = (kind_q == KIND_RESET);

   mbx_word_src #(
      .NPARAM(NPARAM), .IW(IW), .INTNUM_ADDR(INTNUM_ADDR),
      .PARAM_BASE(PARAM_BASE), .ADDR_STRIDE(ADDR_STRIDE),
      .PORTRST_INTNUM(PORTRST_INTNUM), .PORTRST_MS(PORTRST_MS)
   ) u_src (
      .portrst (kind_q == KIND_PORTRST),
      .intnum  (intnum_q),
      .params  (par_q),
      .port    (port_q),
      .unit    (unit_q),
      .idx     (idx),
      .addr    (src_addr),
      .word    (src_word)
   );

   mbx_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (st != ST_WAIT),
      .run     ((st == ST_WAIT) && !mbx_flag),
      .expired (t_expired)
   );

   mbx_reply_class u_cls (
      .reply (m_rdata),
      .code  (cls_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         kind_q   <= KIND_EXEC;
         intnum_q <= '0;
         par_q    <= '0;
         port_q   <= 1'b0;
         unit_q   <= 1'b0;
         idx      <= '0;
         code_q   <= RSP_ACK;
         word_q   <= '0;
      end else begin
         case (st)
            ST_IDLE: if (cmd_valid) begin
               kind_q   <= cmd_kind_e'(cmd_kind);
               intnum_q <= cmd_intnum;
               par_q    <= cmd_params;
               port_q   <= cmd_port;
               unit_q   <= cmd_unit;
               idx      <= '0;
               st       <= (cmd_kind_e'(cmd_kind) == KIND_RESET) ? ST_WMBX : ST_WMEM;
            end
            ST_WMEM: if (m_gnt) begin
               if (idx == IW'(NPARAM)) st <= ST_WMBX;
               else                    idx <= idx + 1'b1;
            end
            ST_WMBX: if (m_gnt) st <= ST_WAIT;
            ST_WAIT: begin
               if (mbx_flag) st <= ST_RMBX;
               else if (t_expired) begin
                  code_q <= RSP_TIMEOUT;
                  word_q <= '0;
                  st     <= ST_RESP;
               end
            end
            ST_RMBX: if (m_gnt) begin
               code_q <= cls_code;
               word_q <= m_rdata;
               st     <= ST_RESP;
            end
            ST_RESP: if (rsp_ready) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      m_req   = (st == ST_WMEM) || (st == ST_WMBX) || (st == ST_RMBX);
      m_we    = (st == ST_WMEM) || (st == ST_WMBX);
      m_mbx   = (st == ST_WMBX) || (st == ST_RMBX);
      m_addr  = (st == ST_WMEM) ? src_addr : 16'd0;
      m_wdata = 16'd0;
      if (st == ST_WMEM)      m_wdata = src_word;
      else if (st == ST_WMBX) m_wdata = is_reset ? TRIG_RESET : TRIG_EXEC;
   end

   assign cmd_ready = (st == ST_IDLE);
   assign busy      = !cmd_ready;
   assign rsp_valid = (st == ST_RESP);
   assign rsp_code  = code_q;
   assign rsp_word  = word_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      m_req && !m_gnt |=> m_req && $stable(m_addr) && $stable(m_wdata) && $stable(m_we) && $stable(m_mbx));  // R11
   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_word));  // R10
   AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_code == RSP_TIMEOUT |-> rsp_word == 16'd0);  // R8
   AST_ACK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_code == RSP_ACK |-> rsp_word == REPLY_ACK);  // R7
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> busy && !cmd_ready);  // R9
   AST_RESET_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      m_req && m_we && !m_mbx |-> kind_q != KIND_RESET);  // R4
endmodule

// File: tb/mbx_cmd_engine_test.sv
module mbx_cmd_engine_test;
   localparam int NP = 14;
   localparam int TO = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic [1:0]        cmd_kind = 2'd0;
   logic [15:0]       cmd_intnum = 16'd0;
   logic [NP*16-1:0]  cmd_params = '0;
   logic              cmd_port = 1'b0;
   logic              cmd_unit = 1'b0;
   logic              rsp_valid;
   logic              rsp_ready = 1'b0;
   logic [1:0]        rsp_code;
   logic [15:0]       rsp_word;
   logic              busy;
   logic              m_req, m_we, m_mbx;
   logic [15:0]       m_addr, m_wdata;
   logic              m_gnt;
   logic [15:0]       m_rdata;
   logic              mbx_flag;

   mbx_cmd_engine #(.NPARAM(NP), .TIMEOUT_CYCLES(TO)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_kind(cmd_kind), .cmd_intnum(cmd_intnum), .cmd_params(cmd_params),
      .cmd_port(cmd_port), .cmd_unit(cmd_unit), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_word(rsp_word),
      .busy(busy), .m_req(m_req), .m_we(m_we), .m_mbx(m_mbx), .m_addr(m_addr),
      .m_wdata(m_wdata), .m_gnt(m_gnt), .m_rdata(m_rdata), .mbx_flag(mbx_flag)
   );

   int nchk = 0;
   int nfail = 0;

   // device model
   int          lat_cfg = 0;
   int          fdly_cfg = 0;
   logic [15:0] reply_cfg = 16'd0;
   logic [15:0] log_addr [0:39];
   logic [15:0] log_data [0:39];
   logic        log_we   [0:39];
   logic        log_mbx  [0:39];
   int          nlog = 0;
   int          stab_err = 0;
   int          wcnt;
   int          fcnt;
   logic        in_wait;
   logic [15:0] hold_addr, hold_wdata;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_gnt    <= 1'b0;
         m_rdata  <= 16'd0;
         mbx_flag <= 1'b0;
         wcnt     <= 0;
         fcnt     <= -1;
         in_wait  <= 1'b0;
      end else begin
         if (fcnt > 0) fcnt <= fcnt - 1;
         else if (fcnt == 0) begin
            mbx_flag <= 1'b1;
            fcnt     <= -1;
         end
         if (m_req && !m_gnt) begin
            if (!in_wait) begin
               hold_addr  <= m_addr;
               hold_wdata <= m_wdata;
               in_wait    <= 1'b1;
            end else if (hold_addr != m_addr || hold_wdata != m_wdata) begin
               stab_err <= stab_err + 1;
            end
            if (wcnt >= lat_cfg) begin
               m_gnt   <= 1'b1;
               wcnt    <= 0;
               in_wait <= 1'b0;
               if (nlog < 40) begin
                  log_addr[nlog] <= m_addr;
                  log_data[nlog] <= m_wdata;
                  log_we[nlog]   <= m_we;
                  log_mbx[nlog]  <= m_mbx;
               end
               nlog <= nlog + 1;
               if (m_mbx && m_we && fdly_cfg >= 0) fcnt <= fdly_cfg;
               if (m_mbx && !m_we) begin
                  m_rdata  <= reply_cfg;
                  mbx_flag <= 1'b0;
               end
            end else begin
               wcnt <= wcnt + 1;
            end
         end else begin
            m_gnt <= 1'b0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic run_cmd(input int kind, input logic [15:0] inum, input int seed,
                          input logic prt, input logic unt, input logic [15:0] reply,
                          input int lat, input int fdly, input int hold, input bit poke);
      logic [15:0] p [NP];
      logic [15:0] ea [0:39];
      logic [15:0] ed [0:39];
      logic        ew [0:39];
      logic        em [0:39];
      int          ne;
      int          bad;
      int          waited;
      int          poke_err;
      logic [1:0]  ecode;
      logic [15:0] eword;
      logic [1:0]  c0;
      logic [15:0] w0;
      string       tag;

      @(negedge clk);
      lat_cfg   = lat;
      fdly_cfg  = fdly;
      reply_cfg = reply;
      nlog      = 0;
      for (int i = 0; i < NP; i++) begin
         p[i] = 16'(seed * 16'h0137 + i * 16'h1111) ^ 16'(i << 3);
         cmd_params[i*16 +: 16] = p[i];
      end
      cmd_kind   = 2'(kind);
      cmd_intnum = inum;
      cmd_port   = prt;
      cmd_unit   = unt;
      cmd_valid  = 1'b1;
      @(negedge clk);
      cmd_valid = poke;
      if (poke) cmd_kind = 2'd1;

      waited   = 0;
      poke_err = 0;
      while (!rsp_valid && waited < 3000) begin
         if (poke && (cmd_ready || !busy)) poke_err++;
         @(negedge clk);
         waited++;
      end
      if (poke) chk(poke_err == 0, "R9", "ready/busy while in flight", 32'(poke_err), 32'd0);
      c0 = rsp_code;
      w0 = rsp_word;
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         chk(rsp_valid && rsp_code == c0 && rsp_word == w0, "R10", "response held",
             {14'd0, rsp_valid, 1'b0, rsp_word}, {14'd0, 1'b1, 1'b0, w0});
      end
      rsp_ready = 1'b1;
      cmd_valid = 1'b0;
      @(negedge clk);
      rsp_ready = 1'b0;

      // expected access sequence
      ne = 0;
      if (kind != 1) begin
         ea[ne] = 16'h01C2; ew[ne] = 1'b1; em[ne] = 1'b0;
         ed[ne] = (kind == 2) ? 16'h0074 : inum;
         ne++;
         for (int i = 0; i < NP; i++) begin
            ea[ne] = 16'(16'h01C4 + 2 * i); ew[ne] = 1'b1; em[ne] = 1'b0;
            if (kind == 2) ed[ne] = (i == 0) ? 16'd50 : (i == 1) ? {14'd0, unt, prt} : 16'd0;
            else           ed[ne] = p[i];
            ne++;
         end
      end
      ea[ne] = 16'd0; ew[ne] = 1'b1; em[ne] = 1'b1;
      ed[ne] = (kind == 1) ? 16'hFA50 : 16'hCE01;
      ne++;
      if (fdly >= 0) begin
         ea[ne] = 16'd0; ew[ne] = 1'b0; em[ne] = 1'b1; ed[ne] = 16'd0;
         ne++;
      end

      tag = (kind == 1) ? "R4" : (kind == 2) ? "R5" : "R1/R2/R3";
      bad = -1;
      if (nlog != ne) bad = 99;
      else begin
         for (int i = ne - 1; i >= 0; i--) begin
            if (log_addr[i] != ea[i] || log_we[i] != ew[i] || log_mbx[i] != em[i] ||
                (ew[i] && log_data[i] != ed[i])) bad = i;
         end
      end
      if (bad == 99) chk(0, tag, "access count", 32'(nlog), 32'(ne));
      else if (bad >= 0)
         chk(0, tag, $sformatf("access %0d addr/data", bad),
             {log_addr[bad], log_data[bad]}, {ea[bad], ed[bad]});
      else chk(1, tag, "sequence", 0, 0);

      if (fdly < 0) begin
         ecode = 2'd3; eword = 16'd0;
      end else begin
         eword = reply;
         ecode = (reply == 16'h0FED) ? 2'd0 : (reply == 16'hDEAD) ? 2'd1 : 2'd2;
      end
      chk(c0 == ecode, (fdly < 0) ? "R8" : "R7", "rsp_code", 32'(c0), 32'(ecode));
      chk(w0 == eword, (fdly < 0) ? "R8" : "R6", "rsp_word", 32'(w0), 32'(eword));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !m_req && !rsp_valid && cmd_ready, "R12", "reset state",
          {28'd0, busy, m_req, rsp_valid, cmd_ready}, 32'h1);

      // sweep: command kind x reply class x grant latency
      for (int k = 0; k < 4; k++) begin
         for (int r = 0; r < 3; r++) begin
            for (int l = 0; l < 3; l += 2) begin
               logic [15:0] rep;
               rep = (r == 0) ? 16'h0FED : (r == 1) ? 16'hDEAD : 16'(16'h5A00 + k * 4 + l);
               run_cmd(k, 16'(16'h0100 + k * 16 + r), k * 7 + r * 3 + l,
                       r[0], (l != 0), rep, l, (r + l) % 4, (r == 1) ? 2 : 0, 1'b0);
            end
         end
      end

      // timeouts, no flag ever raised
      run_cmd(0, 16'h0072, 11, 1'b0, 1'b0, 16'h0FED, 1, -1, 1, 1'b0);
      run_cmd(1, 16'h0000, 12, 1'b0, 1'b0, 16'h0FED, 0, -1, 0, 1'b0);
      run_cmd(2, 16'h0000, 13, 1'b1, 1'b1, 16'h0FED, 2, -1, 0, 1'b0);
      // flag arrives just inside the window
      run_cmd(0, 16'h0073, 14, 1'b0, 1'b0, 16'h0FED, 0, TO - 3, 0, 1'b0);
      // request held high while a command is in flight
      run_cmd(0, 16'h0055, 15, 1'b0, 1'b0, 16'hDEAD, 1, 5, 1, 1'b1);

      chk(stab_err == 0, "R11", "request held stable until grant", 32'(stab_err), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule